// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches 28 external interrupt lines and turns their activity into four interrupt requests for a parent interrupt controller. Every line is first brought into the clock domain through a two-stage synchroniser. A trigger detector then decides, according to a programmable mode, whether the line has produced an event. Events are held in a pending register until software acknowledges them. A mask register decides which pending lines may reach the outputs.

Trigger modes are programmed per pair of adjacent lines, in two configuration words. The unmasked pending lines are ORed into four groups of unequal size, covering lines 0–3, 4–11, 12–19 and 20–27. Software reads and writes the four registers through a word-indexed port with single-cycle access. Read data is combinational on the index, and writes take effect at the clock edge.

Top module: `ext_irq_grouper`

## Requirements
- R1: While reset is held, both configuration words read 0, the mask reads 0x0FFFFFFF, pending reads 0 and all four group outputs are low.
- R2: A change on `ext_in` that is first sampled at rising edge k sets the pending bit at edge k+2. The bit is readable, and visible on the groups, after that edge and not before it.
- R3: The configuration words sit at index 0 (lines 0–15) and index 1 (lines 16–27). The mode of line i is held in bits [s+2:s] with s = ((i mod 16)/2)*4, and both lines of a pair share it. Bit 3 of every nibble reads 0. In word 1, bits 31:24 would belong to lines above 27, so writes to them are rejected and they read 0.
- R4: Mode 000 means low level and 001 means high level. In a level mode the pending bit is set on every cycle in which the synchronised line is at the active level. Mode 000 is the reset value.
- R5: Mode 01x detects a falling edge, 10x a rising edge and 11x both edges. Each transition of the synchronised line sets the pending bit once, and a steady line sets nothing.
- R6: The mask sits at index 2. Bit i = 1 hides line i and bit i = 0 enables it. Bits 31:28 read 0.
- R7: Pending sits at index 3. Writing 1 to bit i clears it, and writing 0 leaves it unchanged. When an event and a clear for the same bit arrive in the same cycle, the bit stays set.
- R8: A clear written while a level-mode line is still at its active level does not leave the bit cleared.
- R9: irq_grp[0], [1], [2] and [3] are high exactly when some line in 0–3, 4–11, 12–19 or 20–27 respectively is pending and unmasked. The outputs follow the register state without an added cycle.
- R10: A masked line still sets its pending bit. Only the group output ignores it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_in | input | 28 | External interrupt lines, asynchronous |
| reg_wr | input | 1 | Write strobe for the register at `reg_addr` |
| reg_addr | input | 2 | Register index: 0 config low, 1 config high, 2 mask, 3 pending (byte offsets 0x0, 0x4, 0x8, 0xC) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr`, combinational |
| irq_grp | output | 4 | Grouped interrupt requests |

## Verification
An input change sampled at edge k reaches the pending register at edge k+2: two edges pass through the synchroniser and one more loads the register. The group outputs and the read data follow that register in the same cycle, and register writes show on the next read after their edge. The bench steps a behavioural model on each rising edge, using the values driven before that edge, and compares read data and groups at every falling edge. That placement keeps each comparison half a cycle away from the edge that produced it. The directed checks count edges explicitly, confirm that pending is still clear one edge before it is due and set on the due edge, and issue clears while a level is held.

// File: rtl/eig_pkg.sv
package eig_pkg;

  typedef enum logic [2:0] {
    TRIG_LOW,
    TRIG_HIGH,
    TRIG_FALL,
    TRIG_RISE,
    TRIG_BOTH
  } trig_e;

  typedef enum logic [1:0] {
    SEL_CFG_LO = 2'd0,
    SEL_CFG_HI = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_PEND   = 2'd3
  } reg_sel_e;

  function automatic trig_e decode_trig(input logic [2:0] field);
    trig_e kind;
    case (field[2:1])
      2'b00:   kind = field[0] ? TRIG_HIGH : TRIG_LOW;
      2'b01:   kind = TRIG_FALL;
      2'b10:   kind = TRIG_RISE;
      default: kind = TRIG_BOTH;
    endcase
    return kind;
  endfunction

endpackage

// File: rtl/eig_sync.sv
module eig_sync #(
  parameter int N = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] cur,
  output logic [N-1:0] prv
);

  logic [N-1:0] meta_q;
  logic [N-1:0] cur_q;
  logic [N-1:0] prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= din;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur = cur_q;
  assign prv = prv_q;

endmodule

// File: rtl/eig_detect.sv
module eig_detect
  import eig_pkg::*;
#(
  parameter int N          = 28,
  parameter int CFG0_LINES = 16,
  parameter int NUM_PAIRS  = 14
) (
  input  logic [NUM_PAIRS-1:0][2:0] mode,
  input  logic [N-1:0]              cur,
  input  logic [N-1:0]              prv,
  output logic [N-1:0]              evt
);

  for (genvar i = 0; i < N; i++) begin : g_line
    localparam int PAIR = (i < CFG0_LINES) ? (i / 2)
                                           : (CFG0_LINES / 2 + (i - CFG0_LINES) / 2);
    trig_e kind;
    logic  hit;

    always_comb begin
      kind = decode_trig(mode[PAIR]);
      case (kind)
        TRIG_LOW:  hit = ~cur[i];
        TRIG_HIGH: hit = cur[i];
        TRIG_FALL: hit = prv[i] & ~cur[i];
        TRIG_RISE: hit = ~prv[i] & cur[i];
        TRIG_BOTH: hit = prv[i] ^ cur[i];
        default:   hit = 1'b0;
      endcase
    end

    assign evt[i] = hit;
  end

endmodule

// File: rtl/eig_regs.sv
module eig_regs
  import eig_pkg::*;
#(
  parameter int N          = 28,
  parameter int CFG0_LINES = 16,
  parameter int NUM_PAIRS  = 14,
  parameter int DW         = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                sel,
  input  logic [DW-1:0]             wdata,
  input  logic [N-1:0]              evt,
  output logic [NUM_PAIRS-1:0][2:0] mode_q,
  output logic [N-1:0]              mask_q,
  output logic [N-1:0]              pend_q,
  output logic [DW-1:0]             rdata
);

  localparam int PAIRS0 = CFG0_LINES / 2;

  reg_sel_e sel_e;
  logic     wr_lo, wr_hi, wr_mask, wr_pend;
  logic     cfg_en;

  logic [NUM_PAIRS-1:0][2:0]    mode_d;
  logic [N-1:0]                 mask_d;
  logic [N-1:0]                 pend_d;
  logic [N-1:0]                 clr_vec;
  logic [NUM_PAIRS-1:0][DW-1:0] lo_parts;
  logic [NUM_PAIRS-1:0][DW-1:0] hi_parts;
  logic [DW-1:0]                rd_lo, rd_hi;
  logic                         unused_wdata;

  assign sel_e        = reg_sel_e'(sel);
  assign unused_wdata = ^wdata;

  always_comb begin
    wr_lo   = wr_en && (sel_e == SEL_CFG_LO);
    wr_hi   = wr_en && (sel_e == SEL_CFG_HI);
    wr_mask = wr_en && (sel_e == SEL_MASK);
    wr_pend = wr_en && (sel_e == SEL_PEND);
    cfg_en  = wr_lo | wr_hi;
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam bit IN_HI = (p >= PAIRS0);
    localparam int SLOT  = IN_HI ? (p - PAIRS0) : p;
    logic take;
    assign take        = IN_HI ? wr_hi : wr_lo;
    assign mode_d[p]   = take ? wdata[SLOT*4 +: 3] : mode_q[p];
    assign lo_parts[p] = IN_HI ? '0 : (DW'(mode_q[p]) << (SLOT * 4));
    assign hi_parts[p] = IN_HI ? (DW'(mode_q[p]) << (SLOT * 4)) : '0;
  end

  always_comb begin
    rd_lo = '0;
    rd_hi = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      rd_lo = rd_lo | lo_parts[p];
      rd_hi = rd_hi | hi_parts[p];
    end
  end

  always_comb begin
    clr_vec = wr_pend ? wdata[N-1:0] : '0;
    pend_d  = (pend_q & ~clr_vec) | evt;
    mask_d  = wdata[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (cfg_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (wr_mask) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_comb begin
    case (sel_e)
      SEL_CFG_LO: rdata = rd_lo;
      SEL_CFG_HI: rdata = rd_hi;
      SEL_MASK:   rdata = DW'(mask_q);
      default:    rdata = DW'(pend_q);
    endcase
  end

endmodule

// File: rtl/ext_irq_grouper.sv
module ext_irq_grouper #(
  parameter int NUM_LINES   = 28,
  parameter int CFG0_LINES  = 16,
  parameter int FIRST_GROUP = 4,
  parameter int GROUP_SPAN  = 8,
  parameter int NUM_GROUPS  = 4,
  parameter int DW          = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  ext_in,
  input  logic                  reg_wr,
  input  logic [1:0]            reg_addr,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  output logic [NUM_GROUPS-1:0] irq_grp
);

  localparam int NUM_PAIRS = CFG0_LINES / 2 + (NUM_LINES - CFG0_LINES + 1) / 2;

  logic [NUM_LINES-1:0]      sync_cur;
  logic [NUM_LINES-1:0]      sync_prv;
  logic [NUM_LINES-1:0]      evt_vec;
  logic [NUM_LINES-1:0]      pend_vec;
  logic [NUM_LINES-1:0]      mask_vec;
  logic [NUM_LINES-1:0]      live_vec;
  logic [NUM_PAIRS-1:0][2:0] mode_vec;

  eig_sync #(.N(NUM_LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ext_in),
    .cur   (sync_cur),
    .prv   (sync_prv)
  );

  eig_detect #(
    .N          (NUM_LINES),
    .CFG0_LINES (CFG0_LINES),
    .NUM_PAIRS  (NUM_PAIRS)
  ) u_detect (
    .mode (mode_vec),
    .cur  (sync_cur),
    .prv  (sync_prv),
    .evt  (evt_vec)
  );

  eig_regs #(
    .N          (NUM_LINES),
    .CFG0_LINES (CFG0_LINES),
    .NUM_PAIRS  (NUM_PAIRS),
    .DW         (DW)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .sel    (reg_addr),
    .wdata  (reg_wdata),
    .evt    (evt_vec),
    .mode_q (mode_vec),
    .mask_q (mask_vec),
    .pend_q (pend_vec),
    .rdata  (reg_rdata)
  );

  assign live_vec = pend_vec & ~mask_vec;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    localparam int LO_B   = (g == 0) ? 0 : FIRST_GROUP + (g - 1) * GROUP_SPAN;
    localparam int HI_RAW = (g == 0) ? FIRST_GROUP - 1 : FIRST_GROUP + g * GROUP_SPAN - 1;
    localparam int HI_B   = (HI_RAW > NUM_LINES - 1) ? NUM_LINES - 1 : HI_RAW;
    assign irq_grp[g] = |live_vec[HI_B:LO_B];
  end

endmodule

// File: rtl/eig_checker.sv
module eig_checker #(
  parameter int N = 28,
  parameter int G = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   waddr,
  input logic [N-1:0] wdata,
  input logic [N-1:0] evt,
  input logic [N-1:0] pend,
  input logic [N-1:0] mask,
  input logic [G-1:0] irq
);

  logic         live_q;
  logic [N-1:0] clr_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  assign clr_now = (wr_en && waddr == 2'd3) ? wdata : '0;

  AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    ((pend & ~$past(pend) & ~$past(evt)) == '0));                               // R2

  AST_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    ((~pend & $past(pend) & ~$past(clr_now)) == '0));                           // R7

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    ((pend & $past(evt)) == $past(evt)));                                       // R8

  AST_GROUPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~mask) == '0) |-> (irq == '0));                                    // R9

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> (irq == '0));                                                   // R6

endmodule

bind ext_irq_grouper eig_checker #(.N(NUM_LINES), .G(NUM_GROUPS)) u_eig_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .wr_en (reg_wr),
  .waddr (reg_addr),
  .wdata (reg_wdata[NUM_LINES-1:0]),
  .evt   (evt_vec),
  .pend  (pend_vec),
  .mask  (mask_vec),
  .irq   (irq_grp)
);

// File: tb/ext_irq_grouper_test.sv
module ext_irq_grouper_test;

  localparam int N = 28;
  localparam int G = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] ext_in;
  logic         reg_wr;
  logic [1:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic [G-1:0] irq_grp;

  always #5 clk = ~clk;

  ext_irq_grouper uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_in    (ext_in),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_grp   (irq_grp)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit model_ok = 1'b0;

  // behavioural reference model
  bit           m_s1 [N];
  bit           m_s2 [N];
  bit           m_pv [N];
  logic [31:0]  m_cfg0, m_cfg1;
  logic [N-1:0] m_mask, m_pend;
  logic [N-1:0] m_ev, m_next;

  function automatic int line_mode(int i);
    logic [31:0] w;
    w = (i < 16) ? m_cfg0 : m_cfg1;
    return int'((w >> (((i % 16) / 2) * 4)) & 32'h7);
  endfunction

  function automatic bit line_event(int i);
    int md;
    md = line_mode(i);
    if (md == 0) return !m_s2[i];
    if (md == 1) return m_s2[i];
    if (md < 4)  return m_pv[i] && !m_s2[i];
    if (md < 6)  return !m_pv[i] && m_s2[i];
    return m_pv[i] != m_s2[i];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_s1[i] = 1'b0; m_s2[i] = 1'b0; m_pv[i] = 1'b0;
      end
      m_cfg0 = '0; m_cfg1 = '0; m_mask = '1; m_pend = '0;
      model_ok = 1'b1;
    end else begin
      for (int i = 0; i < N; i++) m_ev[i] = line_event(i);
      m_next = m_pend;
      if (reg_wr && reg_addr == 2'd3) m_next = m_next & ~reg_wdata[N-1:0];
      m_next = m_next | m_ev;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: m_cfg0 = reg_wdata & 32'h7777_7777;
          2'd1: m_cfg1 = reg_wdata & 32'h0077_7777;
          2'd2: m_mask = reg_wdata[N-1:0];
          default: ;
        endcase
      end
      m_pend = m_next;
      for (int i = 0; i < N; i++) begin
        m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = ext_in[i];
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0:    return m_cfg0;
      2'd1:    return m_cfg1;
      2'd2:    return {4'h0, m_mask};
      default: return {4'h0, m_pend};
    endcase
  endfunction

  function automatic logic [31:0] exp_grp();
    logic [N-1:0] lv;
    lv = m_pend & ~m_mask;
    return {28'h0, |lv[27:20], |lv[19:12], |lv[11:4], |lv[3:0]};
  endfunction

  function automatic string rd_tag(logic [1:0] a);
    case (a)
      2'd0, 2'd1: return "R3";
      2'd2:       return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison, half a cycle after each rising edge
  always @(negedge clk) begin
    if (model_ok && !done) begin
      check_val("R9", {28'h0, irq_grp}, exp_grp());
      check_val(rd_tag(reg_addr), reg_rdata, exp_rd(reg_addr));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic expect_rd(string tag, logic [1:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    check_val(tag, reg_rdata, exp);
  endtask

  task automatic expect_grp(string tag, logic [3:0] exp);
    check_val(tag, {28'h0, irq_grp}, {28'h0, exp});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_in = '0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    tick(3);
    // R1 reset state
    expect_rd("R1", 2'd0, 32'h0);
    expect_rd("R1", 2'd1, 32'h0);
    expect_rd("R1", 2'd2, 32'h0FFF_FFFF);
    expect_rd("R1", 2'd3, 32'h0);
    expect_grp("R1", 4'b0000);

    rst_n = 1'b1;
    tick(2);
    // R4 default low-level mode with lines low sets every pending bit
    expect_rd("R4", 2'd3, 32'h0FFF_FFFF);
    expect_grp("R6", 4'b0000);
    wr(2'd3, 32'h0FFF_FFFF);
    expect_rd("R8", 2'd3, 32'h0FFF_FFFF);

    // R3 layout and rejection of fields above line 27
    wr(2'd1, 32'hFFFF_FFFF);
    expect_rd("R3", 2'd1, 32'h0077_7777);
    wr(2'd0, 32'h1111_1111);
    wr(2'd1, 32'h0011_1111);
    expect_rd("R3", 2'd0, 32'h1111_1111);
    expect_rd("R3", 2'd1, 32'h0011_1111);
    wr(2'd3, 32'h0FFF_FFFF);
    expect_rd("R7", 2'd3, 32'h0);
    wr(2'd2, 32'h0);
    expect_rd("R6", 2'd2, 32'h0);

    // R2 latency on line 5 (high level)
    ext_in[5] = 1'b1;
    tick(2);
    expect_rd("R2", 2'd3, 32'h0);
    expect_grp("R2", 4'b0000);
    tick();
    expect_rd("R2", 2'd3, 32'h20);
    expect_grp("R9", 4'b0010);
    ext_in[5] = 1'b0;
    tick(3);
    wr(2'd3, 32'h20);
    expect_rd("R7", 2'd3, 32'h0);

    // R7 write-zero keeps, write-one clears
    ext_in[12] = 1'b1; tick(3); ext_in[12] = 1'b0; tick(3);
    expect_grp("R9", 4'b0100);
    wr(2'd3, 32'h0);
    expect_rd("R7", 2'd3, 32'h1000);
    wr(2'd3, 32'h0FFF_EFFF);
    expect_rd("R7", 2'd3, 32'h1000);
    wr(2'd3, 32'h1000);
    expect_rd("R7", 2'd3, 32'h0);

    // R8 clear while level persists
    ext_in[20] = 1'b1; tick(3);
    wr(2'd3, 32'h0010_0000);
    expect_rd("R8", 2'd3, 32'h0010_0000);
    expect_grp("R9", 4'b1000);
    ext_in[20] = 1'b0; tick(3);
    wr(2'd3, 32'h0010_0000);
    expect_rd("R8", 2'd3, 32'h0);

    // R5 edge modes: line0/1 falling, line2/3 rising, line4/5 both
    wr(2'd0, 32'h1111_1642);
    ext_in[0] = 1'b1; ext_in[2] = 1'b1; ext_in[4] = 1'b1;
    tick(4);
    expect_rd("R5", 2'd3, 32'h14);
    wr(2'd3, 32'h14);
    ext_in[0] = 1'b0; ext_in[2] = 1'b0; ext_in[4] = 1'b0;
    tick(4);
    expect_rd("R5", 2'd3, 32'h11);
    wr(2'd3, 32'h11);
    tick(4);
    expect_rd("R5", 2'd3, 32'h0);

    // R10 masked line still records
    wr(2'd2, 32'h4);
    ext_in[2] = 1'b1; tick(4);
    expect_rd("R10", 2'd3, 32'h4);
    expect_grp("R10", 4'b0000);
    wr(2'd2, 32'h0);
    expect_grp("R9", 4'b0001);
    ext_in[2] = 1'b0;
    wr(2'd3, 32'h0FFF_FFFF);

    // R9 group boundaries
    ext_in[27] = 1'b1; tick(3);
    expect_grp("R9", 4'b1000);
    ext_in[27] = 1'b0; tick(3);
    wr(2'd3, 32'h0FFF_FFFF);
    expect_grp("R9", 4'b0000);
    ext_in[11] = 1'b1; tick(3);
    expect_grp("R9", 4'b0010);
    ext_in[11] = 1'b0; tick(3);
    wr(2'd3, 32'h0FFF_FFFF);
    ext_in[19] = 1'b1; tick(3);
    expect_grp("R9", 4'b0100);
    ext_in[19] = 1'b0; tick(3);
    wr(2'd3, 32'h0FFF_FFFF);

    // mixed traffic against the model (R4 R5 R7 R9)
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++)
        if (($urandom % 8) == 0) ext_in[i] = ~ext_in[i];
      reg_addr  = 2'($urandom % 4);
      reg_wdata = $urandom;
      reg_wr    = (($urandom % 4) == 0);
      tick();
      reg_wr = 1'b0;
    end

    tick(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule